// File: doc/BRIEF.md
# Ring-Crossing Interrupt Entry and Return Sequencer

This block runs the memory side of taking an interrupt and of returning from one, for a small core with four protection rings (0 is the most privileged). The core keeps its code selector, stack selector, stack pointer, instruction pointer and flags word in this block. It raises a one-cycle request with a vector number to enter a handler, or a one-cycle request to return. The block reads the handler's ring, selector and entry address from an internal table indexed by the vector. When the handler is more privileged than the interrupted code, it moves onto the stack held for that ring in a set of per-ring stack slots. It then writes the return frame word by word through a single-ported memory port and finally loads the handler's state.

On return the block reads the frame back from the current stack. It compares the ring in the saved code selector with the running ring, and from that decides whether two more words (the outer stack pointer and selector) must be read. The outer stack is restored in the same cycle as the outer code ring. Software programs the table and the stack slots, and marks the slot set as armed, through simple write strobes.

Top module: `ring_irq_sequencer`

## Requirements
- R1: The running ring is bits [1:0] of the code selector and the handler ring is the ring field of the table entry for the vector. When the handler ring is numerically lower, the new stack selector and pointer come from the stack slot whose index equals the handler ring.
- R2: On a ring-crossing entry the block writes, at strictly descending word addresses starting 4 below the slot's stack pointer: old stack selector (zero-extended to 32 bits), old stack pointer, flags, old code selector (zero-extended), old instruction pointer.
- R3: When the handler ring equals the running ring there is no stack switch: flags, code selector and instruction pointer are written at the three words below the current stack pointer, in that order.
- R4: A 32-bit error word, taken from the request, is written as the last word only when the table entry's error flag is 1.
- R5: When entry completes, the code selector becomes the entry's selector with bits [1:0] replaced by the handler ring, the instruction pointer becomes the entry address, the stack pointer addresses the last word written, and the flags word is unchanged.
- R6: Entry never writes to the interrupted stack when the ring changes; every write lies on the handler's stack.
- R7: Entry and return never alter the stack slots: a second ring-crossing entry uses exactly the same stack selector and pointer as the first.
- R8: Return reads the instruction pointer at the stack pointer, then the code selector and flags at the next two words up. If bits [1:0] of the read selector differ from the running ring, it also reads the stack pointer and stack selector from the next two words and loads them; otherwise the stack pointer becomes its old value plus 12 and the stack selector is kept.
- R9: The memory port makes one access per cycle. A request holds its address and direction until ready is seen, and consecutive writes step down by 4 while consecutive reads step up by 4.
- R10: If an entry needs a stack switch while the slot set is not armed, or if the handler ring is numerically higher than the running ring, no memory access is made, no register changes, and the fault output rises in the next cycle and stays high until reset.
- R11: Busy is high from the cycle after an accepted request until the final register update. Entry requests, return requests and core register writes arriving while busy have no effect.
- R12: After reset, busy, fault and the memory request are low and all core registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Enter a handler (one-cycle pulse) |
| irq_vec | input | VEC_W | Vector number of the request |
| irq_err | input | 32 | Error word for vectors that carry one |
| ret_req | input | 1 | Return from a handler (one-cycle pulse) |
| busy | output | 1 | Sequence in progress |
| fault | output | 1 | Sticky entry fault |
| core_we | input | 1 | Load the core registers below (idle only) |
| core_cs | input | 16 | Code selector to load |
| core_ss | input | 16 | Stack selector to load |
| core_sp | input | 32 | Stack pointer to load |
| core_ip | input | 32 | Instruction pointer to load |
| core_flags | input | 32 | Flags word to load |
| cur_cs | output | 16 | Current code selector |
| cur_ss | output | 16 | Current stack selector |
| cur_sp | output | 32 | Current stack pointer |
| cur_ip | output | 32 | Current instruction pointer |
| cur_flags | output | 32 | Current flags word |
| gate_we | input | 1 | Write one handler table entry |
| gate_idx | input | VEC_W | Entry index |
| gate_ring | input | 2 | Handler ring |
| gate_sel | input | 16 | Handler code selector |
| gate_entry | input | 32 | Handler entry address |
| gate_err | input | 1 | Vector pushes an error word |
| slot_we | input | 1 | Write one stack slot (index 3 ignored) |
| slot_idx | input | 2 | Stack slot index |
| slot_ss | input | 16 | Slot stack selector |
| slot_sp | input | 32 | Slot stack pointer |
| arm_we | input | 1 | Write the armed flag |
| arm_val | input | 1 | Armed flag value |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with ready |

## Verification
The bench keeps the default VEC_W of 4, giving sixteen table entries, of which it programs vectors with handler rings 0, 1 and 3 and one with the error flag set. That range reaches entries from ring 3 to ring 0, from ring 3 to ring 1 through slot 1, a same-ring entry and return, an outward handler, and an entry with the slots unarmed. A memory model that withholds ready on every third cycle is switched on for half of the sequences so that held requests and the address stepping are exercised under stalls.

// File: rtl/ring_irq_pkg.sv
// Shared constants and types for the ring-crossing interrupt sequencer.
// Assumes 32-bit words, 16-bit selectors and a downward-growing stack.
package ring_irq_pkg;
    localparam int WORD_W     = 32;
    localparam int SEL_W      = 16;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int FRAME_MAX  = 6;
    localparam int NUM_SLOTS  = 3;
    localparam int CNT_W      = $clog2(FRAME_MAX + 1);

    typedef logic [1:0] ring_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PUSH,
        SQ_POP
    } seq_state_t;

    typedef struct packed {
        ring_t              ring;
        logic [SEL_W-1:0]   sel;
        logic [WORD_W-1:0]  entry;
        logic               has_err;
    } gate_t;
endpackage

// File: rtl/ring_irq_gate_table.sv
// Handler table: one entry per vector, written by software, read
// combinationally with the vector of the request being accepted.
// Assumes writes and reads of the same entry do not coincide.
module ring_irq_gate_table
    import ring_irq_pkg::*;
#(
    parameter int VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_idx,
    input  gate_t            wr_gate,
    input  logic [VEC_W-1:0] rd_idx,
    output gate_t            rd_gate
);
    localparam int DEPTH = 1 << VEC_W;

    gate_t tab_q [DEPTH];

    // Store or clear table entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= '0;
        end else if (wr_en) begin
            tab_q[wr_idx] <= wr_gate;
        end
    end

    // Present the entry for the requested vector.
    always_comb rd_gate = tab_q[rd_idx];
endmodule

// File: rtl/ring_irq_stack_slots.sv
// Per-ring stack slots for rings 0..2 plus an armed flag. Entry and
// return only read these; software alone writes them. Slot index 3
// has no storage and writes to it are dropped.
module ring_irq_stack_slots
    import ring_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ring_t             wr_slot,
    input  logic [SEL_W-1:0]  wr_ss,
    input  logic [WORD_W-1:0] wr_sp,
    input  logic              arm_we,
    input  logic              arm_val,
    input  ring_t             rd_slot,
    output logic [SEL_W-1:0]  rd_ss,
    output logic [WORD_W-1:0] rd_sp,
    output logic              armed
);
    logic [SEL_W-1:0]  ss_q [NUM_SLOTS];
    logic [WORD_W-1:0] sp_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Hold one slot's stack selector and pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ss_q[g] <= '0;
                sp_q[g] <= '0;
            end else if (wr_en && (wr_slot == ring_t'(g))) begin
                ss_q[g] <= wr_ss;
                sp_q[g] <= wr_sp;
            end
        end
    end

    // Hold the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (arm_we) armed <= arm_val;
    end

    // Select the slot for the handler ring.
    always_comb begin
        rd_ss = '0;
        rd_sp = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_slot == ring_t'(i)) begin
                rd_ss = ss_q[i];
                rd_sp = sp_q[i];
            end
        end
    end
endmodule

// File: rtl/ring_irq_engine.sv
// Entry/return state machine and the core register set. On an accepted
// entry it snapshots the whole frame, then writes it one word per
// handshake; on return it reads three or five words, deciding after the
// second read. Assumes mem_rdata is valid in the cycle ready is high.
module ring_irq_engine
    import ring_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [WORD_W-1:0] irq_err,
    input  gate_t             gate_i,
    input  logic              ret_req,
    input  logic              core_we,
    input  logic [SEL_W-1:0]  core_cs,
    input  logic [SEL_W-1:0]  core_ss,
    input  logic [WORD_W-1:0] core_sp,
    input  logic [WORD_W-1:0] core_ip,
    input  logic [WORD_W-1:0] core_flags,
    input  logic [SEL_W-1:0]  slot_ss,
    input  logic [WORD_W-1:0] slot_sp,
    input  logic              slots_armed,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              fault,
    output logic [SEL_W-1:0]  cur_cs,
    output logic [SEL_W-1:0]  cur_ss,
    output logic [WORD_W-1:0] cur_sp,
    output logic [WORD_W-1:0] cur_ip,
    output logic [WORD_W-1:0] cur_flags
);
    localparam logic [WORD_W-1:0] STEP     = WORD_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  POP_BASE = CNT_W'(3);
    localparam logic [CNT_W-1:0]  POP_FULL = CNT_W'(5);

    seq_state_t        st_q;
    logic [SEL_W-1:0]  cs_q, ss_q, hcs_q, nss_q;
    logic [WORD_W-1:0] sp_q, ip_q, fl_q, wsp_q, hip_q;
    logic [WORD_W-1:0] frm_q [FRAME_MAX];
    logic [WORD_W-1:0] pop_q [FRAME_MAX];
    logic [WORD_W-1:0] fb    [FRAME_MAX];
    logic [WORD_W-1:0] pw    [FRAME_MAX];
    logic [CNT_W-1:0]  idx_q, cnt_q, fcnt;
    logic              fault_q;

    ring_t cur_ring;
    logic  idle, take_irq, take_ret, need_sw, outward, irq_bad, hs, at_last;

    // Decode the request against the running ring.
    always_comb begin
        cur_ring = ring_t'(cs_q[1:0]);
        need_sw  = gate_i.ring < cur_ring;
        outward  = gate_i.ring > cur_ring;
        idle     = (st_q == SQ_IDLE);
        take_irq = idle && irq_req;
        take_ret = idle && !irq_req && ret_req;
        irq_bad  = outward || (need_sw && !slots_armed);
        hs       = mem_valid && mem_ready;
        at_last  = (idx_q + CNT_W'(1)) == cnt_q;
    end

    // Assemble the entry frame in write order.
    always_comb begin
        for (int i = 0; i < FRAME_MAX; i++) fb[i] = '0;
        if (need_sw) begin
            fb[0] = WORD_W'(ss_q);
            fb[1] = sp_q;
            fb[2] = fl_q;
            fb[3] = WORD_W'(cs_q);
            fb[4] = ip_q;
            fb[5] = irq_err;
            fcnt  = gate_i.has_err ? CNT_W'(6) : CNT_W'(5);
        end else begin
            fb[0] = fl_q;
            fb[1] = WORD_W'(cs_q);
            fb[2] = ip_q;
            fb[3] = irq_err;
            fcnt  = gate_i.has_err ? CNT_W'(4) : CNT_W'(3);
        end
    end

    // Merge the word being read into the words already read.
    always_comb begin
        for (int i = 0; i < FRAME_MAX; i++)
            pw[i] = (CNT_W'(i) == idx_q) ? mem_rdata : pop_q[i];
    end

    // Drive the memory port from the sequence state.
    always_comb begin
        mem_valid = (st_q != SQ_IDLE);
        mem_we    = (st_q == SQ_PUSH);
        mem_addr  = mem_we ? (wsp_q - STEP) : wsp_q;
        mem_wdata = frm_q[idx_q];
    end

    // Advance the sequence and its working stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            wsp_q   <= '0;
            hcs_q   <= '0;
            nss_q   <= '0;
            hip_q   <= '0;
            fault_q <= 1'b0;
            for (int i = 0; i < FRAME_MAX; i++) begin
                frm_q[i] <= '0;
                pop_q[i] <= '0;
            end
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (take_irq) begin
                        if (irq_bad) begin
                            fault_q <= 1'b1;
                        end else begin
                            st_q  <= SQ_PUSH;
                            idx_q <= '0;
                            cnt_q <= fcnt;
                            frm_q <= fb;
                            wsp_q <= need_sw ? slot_sp : sp_q;
                            nss_q <= need_sw ? slot_ss : ss_q;
                            hcs_q <= {gate_i.sel[SEL_W-1:2], gate_i.ring};
                            hip_q <= gate_i.entry;
                        end
                    end else if (take_ret) begin
                        st_q  <= SQ_POP;
                        idx_q <= '0;
                        cnt_q <= POP_BASE;
                        wsp_q <= sp_q;
                    end
                end
                SQ_PUSH: begin
                    if (hs) begin
                        wsp_q <= wsp_q - STEP;
                        idx_q <= idx_q + CNT_W'(1);
                        if (at_last) st_q <= SQ_IDLE;
                    end
                end
                SQ_POP: begin
                    if (hs) begin
                        pop_q[idx_q] <= mem_rdata;
                        wsp_q        <= wsp_q + STEP;
                        idx_q        <= idx_q + CNT_W'(1);
                        if (idx_q == CNT_W'(1))
                            cnt_q <= (mem_rdata[1:0] != cs_q[1:0]) ? POP_FULL : POP_BASE;
                        if (at_last) st_q <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Update the core registers from software or at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
            ss_q <= '0;
            sp_q <= '0;
            ip_q <= '0;
            fl_q <= '0;
        end else if (idle && core_we) begin
            cs_q <= core_cs;
            ss_q <= core_ss;
            sp_q <= core_sp;
            ip_q <= core_ip;
            fl_q <= core_flags;
        end else if ((st_q == SQ_PUSH) && hs && at_last) begin
            cs_q <= hcs_q;
            ss_q <= nss_q;
            sp_q <= mem_addr;
            ip_q <= hip_q;
        end else if ((st_q == SQ_POP) && hs && at_last) begin
            ip_q <= pw[0];
            cs_q <= pw[1][SEL_W-1:0];
            fl_q <= pw[2];
            if (cnt_q == POP_FULL) begin
                sp_q <= pw[3];
                ss_q <= pw[4][SEL_W-1:0];
            end else begin
                sp_q <= wsp_q + STEP;
            end
        end
    end

    // Expose state.
    always_comb begin
        busy      = (st_q != SQ_IDLE);
        fault     = fault_q;
        cur_cs    = cs_q;
        cur_ss    = ss_q;
        cur_sp    = sp_q;
        cur_ip    = ip_q;
        cur_flags = fl_q;
    end
endmodule

// File: rtl/ring_irq_sequencer.sv
// Top: handler table, per-ring stack slots and the entry/return engine.
// Assumes software programs table and slots while no sequence runs.
module ring_irq_sequencer
    import ring_irq_pkg::*;
#(
    parameter int VEC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [WORD_W-1:0] irq_err,
    input  logic              ret_req,
    output logic              busy,
    output logic              fault,
    input  logic              core_we,
    input  logic [SEL_W-1:0]  core_cs,
    input  logic [SEL_W-1:0]  core_ss,
    input  logic [WORD_W-1:0] core_sp,
    input  logic [WORD_W-1:0] core_ip,
    input  logic [WORD_W-1:0] core_flags,
    output logic [SEL_W-1:0]  cur_cs,
    output logic [SEL_W-1:0]  cur_ss,
    output logic [WORD_W-1:0] cur_sp,
    output logic [WORD_W-1:0] cur_ip,
    output logic [WORD_W-1:0] cur_flags,
    input  logic              gate_we,
    input  logic [VEC_W-1:0]  gate_idx,
    input  logic [1:0]        gate_ring,
    input  logic [SEL_W-1:0]  gate_sel,
    input  logic [WORD_W-1:0] gate_entry,
    input  logic              gate_err,
    input  logic              slot_we,
    input  logic [1:0]        slot_idx,
    input  logic [SEL_W-1:0]  slot_ss,
    input  logic [WORD_W-1:0] slot_sp,
    input  logic              arm_we,
    input  logic              arm_val,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);
    gate_t             wr_gate, rd_gate;
    logic [SEL_W-1:0]  sel_ss;
    logic [WORD_W-1:0] sel_sp;
    logic              armed;

    // Pack the table write fields.
    always_comb wr_gate = '{ring: gate_ring, sel: gate_sel, entry: gate_entry, has_err: gate_err};

    ring_irq_gate_table #(.VEC_W(VEC_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gate_we),
        .wr_idx  (gate_idx),
        .wr_gate (wr_gate),
        .rd_idx  (irq_vec),
        .rd_gate (rd_gate)
    );

    ring_irq_stack_slots u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_we),
        .wr_slot (slot_idx),
        .wr_ss   (slot_ss),
        .wr_sp   (slot_sp),
        .arm_we  (arm_we),
        .arm_val (arm_val),
        .rd_slot (rd_gate.ring),
        .rd_ss   (sel_ss),
        .rd_sp   (sel_sp),
        .armed   (armed)
    );

    ring_irq_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .irq_err     (irq_err),
        .gate_i      (rd_gate),
        .ret_req     (ret_req),
        .core_we     (core_we),
        .core_cs     (core_cs),
        .core_ss     (core_ss),
        .core_sp     (core_sp),
        .core_ip     (core_ip),
        .core_flags  (core_flags),
        .slot_ss     (sel_ss),
        .slot_sp     (sel_sp),
        .slots_armed (armed),
        .mem_valid   (mem_valid),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .fault       (fault),
        .cur_cs      (cur_cs),
        .cur_ss      (cur_ss),
        .cur_sp      (cur_sp),
        .cur_ip      (cur_ip),
        .cur_flags   (cur_flags)
    );
endmodule

// File: rtl/ring_irq_sequencer_chk.sv
// Protocol checker for the sequencer, attached with bind below.
module ring_irq_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        fault,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [15:0] cur_cs
);
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R10
    AST_FAULT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> (!busy && !mem_valid)); // R10
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> (!(mem_valid && mem_we) || (mem_addr == $past(mem_addr) - 32'd4))); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_we) |=> (!(mem_valid && !mem_we) || (mem_addr == $past(mem_addr) + 32'd4))); // R8
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid); // R11
    AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_valid && mem_ready)) |=> $stable(cur_cs)); // R11
endmodule

bind ring_irq_sequencer ring_irq_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .fault     (fault),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .cur_cs    (cur_cs)
);

// File: tb/ring_irq_sequencer_tb_top.sv
// Scoreboard bench: tasks queue the expected frame writes, a monitor at
// the falling edge pops and compares each completed write.
module ring_irq_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, ret_req = 1'b0;
    logic [3:0]  irq_vec = '0;
    logic [31:0] irq_err = '0;
    logic        busy, fault;
    logic        core_we = 1'b0;
    logic [15:0] core_cs = '0, core_ss = '0;
    logic [31:0] core_sp = '0, core_ip = '0, core_flags = '0;
    logic [15:0] cur_cs, cur_ss;
    logic [31:0] cur_sp, cur_ip, cur_flags;
    logic        gate_we = 1'b0, gate_err = 1'b0;
    logic [3:0]  gate_idx = '0;
    logic [1:0]  gate_ring = '0;
    logic [15:0] gate_sel = '0;
    logic [31:0] gate_entry = '0;
    logic        slot_we = 1'b0;
    logic [1:0]  slot_idx = '0;
    logic [15:0] slot_ss = '0;
    logic [31:0] slot_sp = '0;
    logic        arm_we = 1'b0, arm_val = 1'b0;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t         exp_q [$];
    logic [31:0] mem_arr [256];
    int          n_chk = 0, n_fail = 0, outer_wr = 0, cyc = 0;
    logic        stall = 1'b0;

    always #10 clk = ~clk;

    ring_irq_sequencer #(.VEC_W(4)) dut_i (.*);

    assign mem_ready = !stall || ((cyc % 3) != 2);
    assign mem_rdata = mem_arr[mem_addr[9:2]];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each completed write against the queue.
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && mem_we) begin
            mem_arr[mem_addr[9:2]] = mem_wdata;
            if (mem_addr >= 32'h200) outer_wr++;
            if (exp_q.size() == 0) begin
                chk("R2 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk("R2 push addr", mem_addr, e.a);
                chk("R2 push data", mem_wdata, e.d);
            end
        end
    end

    task automatic expect_push(input logic [31:0] a, input logic [31:0] d);
        wr_t e;
        e.a = a;
        e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_gate(input logic [3:0] v, input logic [1:0] r, input logic [15:0] s,
                            input logic [31:0] en, input logic er);
        gate_we = 1'b1; gate_idx = v; gate_ring = r; gate_sel = s; gate_entry = en; gate_err = er;
        @(negedge clk);
        gate_we = 1'b0;
    endtask

    task automatic set_slot(input logic [1:0] i, input logic [15:0] s, input logic [31:0] p);
        slot_we = 1'b1; slot_idx = i; slot_ss = s; slot_sp = p;
        @(negedge clk);
        slot_we = 1'b0;
    endtask

    task automatic core_load(input logic [15:0] c, input logic [15:0] s, input logic [31:0] p,
                             input logic [31:0] ip, input logic [31:0] f);
        core_we = 1'b1; core_cs = c; core_ss = s; core_sp = p; core_ip = ip; core_flags = f;
        @(negedge clk);
        core_we = 1'b0;
    endtask

    task automatic setup_tables();
        set_gate(4'd5, 2'd0, 16'h0008, 32'h0000_8000, 1'b0);
        set_gate(4'd6, 2'd0, 16'h0008, 32'h0000_8800, 1'b1);
        set_gate(4'd7, 2'd3, 16'h0018, 32'h0000_A000, 1'b0);
        set_gate(4'd8, 2'd1, 16'h0028, 32'h0000_9000, 1'b0);
        set_slot(2'd0, 16'h0010, 32'h0000_0100);
        set_slot(2'd1, 16'h0031, 32'h0000_0180);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic fire_irq(input logic [3:0] v, input logic [31:0] e);
        irq_vec = v; irq_err = e; irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic fire_ret();
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
    endtask

    task automatic check_regs(input string req, input logic [15:0] c, input logic [15:0] s,
                              input logic [31:0] p, input logic [31:0] ip, input logic [31:0] f);
        chk({req, " cs"}, 32'(cur_cs), 32'(c));
        chk({req, " ss"}, 32'(cur_ss), 32'(s));
        chk({req, " sp"}, cur_sp, p);
        chk({req, " ip"}, cur_ip, ip);
        chk({req, " flags"}, cur_flags, f);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", n_chk);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = '0;
        do_reset();
        // R12: reset state
        chk("R12 busy", 32'(busy), 0);
        chk("R12 fault", 32'(fault), 0);
        chk("R12 mem_valid", 32'(mem_valid), 0);
        check_regs("R12", 16'h0, 16'h0, 0, 0, 0);

        setup_tables();
        arm_we = 1'b1; arm_val = 1'b1; @(negedge clk); arm_we = 1'b0;

        // R1 R2 R5 R6 R11: ring 3 -> ring 0, requests during busy ignored
        core_load(16'h001B, 16'h0023, 32'h300, 32'h1000, 32'h202);
        expect_push(32'h0FC, 32'h23);
        expect_push(32'h0F8, 32'h300);
        expect_push(32'h0F4, 32'h202);
        expect_push(32'h0F0, 32'h1B);
        expect_push(32'h0EC, 32'h1000);
        fire_irq(4'd5, 32'h0);
        chk("R11 busy after accept", 32'(busy), 1);
        irq_req = 1'b1; irq_vec = 4'd6; ret_req = 1'b1;
        core_we = 1'b1; core_cs = 16'h0003; core_sp = 32'h1234;
        @(negedge clk);
        irq_req = 1'b0; ret_req = 1'b0; core_we = 1'b0;
        wait_idle();
        check_regs("R5", 16'h0008, 16'h0010, 32'h0EC, 32'h8000, 32'h202);
        chk("R2 frame complete", 32'(exp_q.size()), 0);
        chk("R6 outer writes", 32'(outer_wr), 0);

        // R8: return undoing the switch
        fire_ret();
        wait_idle();
        check_regs("R8 cross", 16'h001B, 16'h0023, 32'h300, 32'h1000, 32'h202);

        // R4 R7 R9: entry with error word under stalls, slot unchanged
        stall = 1'b1;
        expect_push(32'h0FC, 32'h23);
        expect_push(32'h0F8, 32'h300);
        expect_push(32'h0F4, 32'h202);
        expect_push(32'h0F0, 32'h1B);
        expect_push(32'h0EC, 32'h1000);
        expect_push(32'h0E8, 32'hDEAD);
        fire_irq(4'd6, 32'hDEAD);
        wait_idle();
        check_regs("R7 R4", 16'h0008, 16'h0010, 32'h0E8, 32'h8800, 32'h202);
        chk("R4 frame complete", 32'(exp_q.size()), 0);
        core_load(16'h0008, 16'h0010, 32'h0EC, 32'h8804, 32'h202);
        fire_ret();
        wait_idle();
        check_regs("R9 R8 stalled return", 16'h001B, 16'h0023, 32'h300, 32'h1000, 32'h202);

        // R3: same-ring entry and return
        core_load(16'h0008, 16'h0010, 32'h1C0, 32'h2222, 32'h46);
        expect_push(32'h1BC, 32'h46);
        expect_push(32'h1B8, 32'h08);
        expect_push(32'h1B4, 32'h2222);
        fire_irq(4'd5, 32'h0);
        wait_idle();
        check_regs("R3", 16'h0008, 16'h0010, 32'h1B4, 32'h8000, 32'h46);
        chk("R3 frame complete", 32'(exp_q.size()), 0);
        fire_ret();
        wait_idle();
        check_regs("R8 same ring", 16'h0008, 16'h0010, 32'h1C0, 32'h2222, 32'h46);
        stall = 1'b0;

        // R1: ring 3 -> ring 1 uses slot 1
        core_load(16'h001B, 16'h0023, 32'h300, 32'h3000, 32'h2);
        expect_push(32'h17C, 32'h23);
        expect_push(32'h178, 32'h300);
        expect_push(32'h174, 32'h2);
        expect_push(32'h170, 32'h1B);
        expect_push(32'h16C, 32'h3000);
        fire_irq(4'd8, 32'h0);
        wait_idle();
        check_regs("R1 slot1", 16'h0029, 16'h0031, 32'h16C, 32'h9000, 32'h2);
        chk("R6 outer writes total", 32'(outer_wr), 0);

        // R10: outward handler faults, nothing written, sticky
        fire_irq(4'd7, 32'h0);
        chk("R10 outward fault", 32'(fault), 1);
        chk("R10 outward busy", 32'(busy), 0);
        chk("R10 outward mem_valid", 32'(mem_valid), 0);
        check_regs("R10 outward regs", 16'h0029, 16'h0031, 32'h16C, 32'h9000, 32'h2);
        repeat (3) @(negedge clk);
        chk("R10 sticky", 32'(fault), 1);

        // R10: unarmed slots fault
        do_reset();
        chk("R12 fault cleared", 32'(fault), 0);
        setup_tables();
        core_load(16'h001B, 16'h0023, 32'h300, 32'h1000, 32'h202);
        fire_irq(4'd5, 32'h0);
        chk("R10 unarmed fault", 32'(fault), 1);
        chk("R10 unarmed mem_valid", 32'(mem_valid), 0);
        @(negedge clk);
        check_regs("R10 unarmed regs", 16'h001B, 16'h0023, 32'h300, 32'h1000, 32'h202);
        chk("R10 no writes", 32'(exp_q.size()), 0);

        summary();
        $finish;
    end
endmodule